// File: doc/BRIEF.md
# Sequential Five-Step RV32 Integer Core

A small 32-bit integer processor that never overlaps instructions. Every instruction walks through five one-cycle steps: fetch, decode, execute, memory access and register writeback. The first two steps are identical for every instruction. Decode picks a seven-field control word from a fixed table, and that word steers the last three steps: ALU operand source, ALU function, branch selection, memory read, memory write, writeback source and register write enable. Only add, sub, addi, lw, sw, beq, bne, blt and bge are understood. A fetched word with any other encoding runs through the five steps with an all-zero control word and simply advances the PC.

Code and data share one word-organised memory. While the core is held in reset, the environment fills that memory through a load port. After reset is released, the core runs from address 0. It stops when it fetches a word whose opcode field is zero, or when its retired-instruction budget is used up. A combinational peek port and the `pc` and `halted` outputs expose the architectural state for checking.

Top module: `seqrv_core`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0 and `halted` reads 0. Every register x1..x31 reads 0 through the peek port after a reset.
- R2: Each non-halting instruction takes exactly 5 clock cycles. Once reset is released, a program of N instructions followed by a stop word raises `halted` after 5N+2 rising edges. `pc` only changes on the edge that ends the execute step.
- R3: add and sub (opcode 0110011, funct3 000, funct7 0000000 or 0100000) and addi (opcode 0010011, funct3 000) compute modulo 2^32. The addi immediate is instruction bits 31:20, sign-extended.
- R4: lw (opcode 0000011, funct3 010) and sw (opcode 0100011, funct3 010) use byte address rs1 plus a sign-extended immediate. The word index is that address divided by 4. The store immediate is {bits 31:25, bits 11:7}. Addresses beyond the memory read as 0 and ignore stores.
- R5: beq, bne, blt and bge (opcode 1100011, funct3 000, 001, 100, 101) compare rs1 with rs2, signed for blt and bge. A true condition sets the next `pc` to `pc` plus the sign-extended B-type offset {bit31, bit7, bits 30:25, bits 11:8, 0}. Otherwise the next `pc` is `pc`+4.
- R6: A fetched word whose bits 6:0 are zero sets `halted`. `pc` then holds that word's address, and both stay unchanged until the next reset.
- R7: After MAX_INSTR retired instructions the core sets `halted` and stops, even if the program has not reached a stop word.
- R8: Register x0 always reads 0. An instruction whose destination is x0 changes no register.
- R9: With `load_we` high, `load_data` is written into the memory word indexed by `load_addr` on the rising edge. The load port takes priority over a store from the core.
- R10: `pc` is always a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Memory load strobe |
| load_addr | input | $clog2(MEM_WORDS) | Word index for the load port |
| load_data | input | 32 | Word written by the load port |
| peek_sel | input | 5 | Register number to observe |
| peek_data | output | 32 | Current value of register `peek_sel` |
| pc | output | 32 | Program counter (byte address) |
| halted | output | 1 | Core has stopped |

## Verification
The bench releases reset on a falling edge and counts rising edges until `halted` first appears. That count must equal 5N+2 for an N-instruction program, or 5*MAX_INSTR for the budget case. Register and PC results are read only after `halted`, when no further writeback can land. Peek reads happen one time unit after `peek_sel` changes, on a falling edge, so all sampling stays away from the active edge.

// File: rtl/seqrv_pkg.sv
package seqrv_pkg;

   typedef enum logic [2:0] {
      ALU_AND = 3'd0,
      ALU_OR  = 3'd1,
      ALU_ADD = 3'd2,
      ALU_SUB = 3'd3,
      ALU_EQ  = 3'd4,
      ALU_NE  = 3'd5,
      ALU_LT  = 3'd6,
      ALU_GE  = 3'd7
   } alu_op_t;

   // Field order follows the order of use across execute, memory and writeback.
   typedef struct packed {
      logic    asrc;
      alu_op_t alu_op;
      logic    branch;
      logic    mread;
      logic    mwrite;
      logic    mtor;
      logic    rwrite;
   } ctrl_t;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WB     = 3'd4,
      ST_HALT   = 3'd5
   } step_t;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

endpackage

// File: rtl/seqrv_decode.sv
module seqrv_decode
   import seqrv_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     ir,
   output ctrl_t           ctrl,
   output logic [XLEN-1:0] imm,
   output logic [XLEN-1:0] boff,
   output logic [4:0]      rs1,
   output logic [4:0]      rs2,
   output logic [4:0]      rd,
   output logic            stop
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;

   assign opc  = ir[6:0];
   assign f3   = ir[14:12];
   assign f7   = ir[31:25];
   assign rs1  = ir[19:15];
   assign rs2  = ir[24:20];
   assign rd   = ir[11:7];
   assign stop = (opc == 7'd0);

   logic [XLEN-1:0] imm_i, imm_s;
   assign imm_i = {{(XLEN-12){ir[31]}}, ir[31:20]};
   assign imm_s = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
   assign imm   = (opc == OPC_STORE) ? imm_s : imm_i;
   assign boff  = {{(XLEN-13){ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};

   always_comb begin
      ctrl = '0;
      unique case (opc)
         OPC_REG: begin
            if (f3 == 3'b000 && f7 == 7'b0000000)
               ctrl = '{1'b0, ALU_ADD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
            else if (f3 == 3'b000 && f7 == 7'b0100000)
               ctrl = '{1'b0, ALU_SUB, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
         end
         OPC_IMM: begin
            if (f3 == 3'b000)
               ctrl = '{1'b1, ALU_ADD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
         end
         OPC_LOAD: begin
            if (f3 == 3'b010)
               ctrl = '{1'b1, ALU_ADD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
         end
         OPC_STORE: begin
            if (f3 == 3'b010)
               ctrl = '{1'b1, ALU_ADD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
         end
         OPC_BRANCH: begin
            unique case (f3)
               3'b000:  ctrl = '{1'b0, ALU_EQ, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
               3'b001:  ctrl = '{1'b0, ALU_NE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
               3'b100:  ctrl = '{1'b0, ALU_LT, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
               3'b101:  ctrl = '{1'b0, ALU_GE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
               default: ctrl = '0;
            endcase
         end
         default: ctrl = '0;
      endcase
   end

endmodule

// File: rtl/seqrv_alu.sv
module seqrv_alu
   import seqrv_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_t         op,
   output logic [XLEN-1:0] y,
   output logic            flag
);

   logic lt_s;
   assign lt_s = $signed(a) < $signed(b);

   always_comb begin
      flag = 1'b0;
      y    = '0;
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_EQ:  flag = (a == b);
         ALU_NE:  flag = (a != b);
         ALU_LT:  flag = lt_s;
         ALU_GE:  flag = !lt_s;
         default: y = '0;
      endcase
      if (op inside {ALU_EQ, ALU_NE, ALU_LT, ALU_GE})
         y = {{(XLEN-1){1'b0}}, flag};
   end

endmodule

// File: rtl/seqrv_regs.sv
module seqrv_regs #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [RW-1:0]   ra1,
   input  logic [RW-1:0]   ra2,
   input  logic [RW-1:0]   rap,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   output logic [XLEN-1:0] rdp
);

   logic [XLEN-1:0] rf [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign rf[i] = '0;
      end else begin : g_live
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (we && waddr == RW'(i))
               q <= wdata;
         end
         assign rf[i] = q;
      end
   end

   assign rd1 = rf[ra1];
   assign rd2 = rf[ra2];
   assign rdp = rf[rap];

endmodule

// File: rtl/seqrv_core.sv
module seqrv_core
   import seqrv_pkg::*;
#(
   parameter int MEM_WORDS = 1000,
   parameter int MAX_INSTR = 10000,
   localparam int AW   = $clog2(MEM_WORDS),
   localparam int CW   = $clog2(MAX_INSTR + 1),
   localparam int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_we,
   input  logic [AW-1:0]   load_addr,
   input  logic [31:0]     load_data,
   input  logic [4:0]      peek_sel,
   output logic [31:0]     peek_data,
   output logic [31:0]     pc,
   output logic            halted
);

   if (MEM_WORDS < 2 || MEM_WORDS > 4096) begin : g_bad_mem
      $error("MEM_WORDS out of supported range");
   end
   if (MAX_INSTR < 1) begin : g_bad_budget
      $error("MAX_INSTR must be positive");
   end

   localparam logic [29:0]   MEM_LIM  = 30'(MEM_WORDS);
   localparam logic [CW-1:0] CNT_LAST = CW'(MAX_INSTR - 1);

   logic [31:0] mem [MEM_WORDS];

   step_t           step_q;
   logic [XLEN-1:0] pc_q, imm_q, boff_q, aout_q, sdata_q, mout_q;
   logic [31:0]     ir_q;
   ctrl_t           ctrl_q;
   logic [4:0]      rs1_q, rs2_q, rd_q;
   logic [CW-1:0]   cnt_q;
   logic            halted_q;

   // decode of the held instruction word
   ctrl_t           dec_ctrl;
   logic [XLEN-1:0] dec_imm, dec_boff;
   logic [4:0]      dec_rs1, dec_rs2, dec_rd;
   logic            dec_stop;

   seqrv_decode #(.XLEN(XLEN)) u_dec (
      .ir   (ir_q),
      .ctrl (dec_ctrl),
      .imm  (dec_imm),
      .boff (dec_boff),
      .rs1  (dec_rs1),
      .rs2  (dec_rs2),
      .rd   (dec_rd),
      .stop (dec_stop)
   );

   // register file
   logic [XLEN-1:0] r1, r2, wb_data;
   logic            wb_en;

   assign wb_en   = (step_q == ST_WB) && ctrl_q.rwrite;
   assign wb_data = ctrl_q.mtor ? mout_q : aout_q;

   seqrv_regs #(.XLEN(XLEN), .NREG(32)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wb_en),
      .waddr (rd_q),
      .wdata (wb_data),
      .ra1   (rs1_q),
      .ra2   (rs2_q),
      .rap   (peek_sel),
      .rd1   (r1),
      .rd2   (r2),
      .rdp   (peek_data)
   );

   // ALU with operand select
   logic [XLEN-1:0] alu_b, alu_y;
   logic            alu_flag;

   assign alu_b = ctrl_q.asrc ? imm_q : r2;

   seqrv_alu #(.XLEN(XLEN)) u_alu (
      .a    (r1),
      .b    (alu_b),
      .op   (ctrl_q.alu_op),
      .y    (alu_y),
      .flag (alu_flag)
   );

   // memory port decode
   logic          fetch_ok, data_ok;
   logic [AW-1:0] fetch_idx, data_idx;

   assign fetch_ok  = pc_q[31:2] < MEM_LIM;
   assign data_ok   = aout_q[31:2] < MEM_LIM;
   assign fetch_idx = pc_q[AW+1:2];
   assign data_idx  = aout_q[AW+1:2];

   always_ff @(posedge clk) begin
      if (load_we) begin
         if (load_addr < AW'(MEM_WORDS))
            mem[load_addr] <= load_data;
      end else if (step_q == ST_MEM && ctrl_q.mwrite && data_ok) begin
         mem[data_idx] <= sdata_q;
      end
   end

   // step sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q   <= ST_FETCH;
         pc_q     <= '0;
         ir_q     <= '0;
         ctrl_q   <= '0;
         imm_q    <= '0;
         boff_q   <= '0;
         rs1_q    <= '0;
         rs2_q    <= '0;
         rd_q     <= '0;
         aout_q   <= '0;
         sdata_q  <= '0;
         mout_q   <= '0;
         cnt_q    <= '0;
         halted_q <= 1'b0;
      end else begin
         unique case (step_q)
            ST_FETCH: begin
               ir_q   <= fetch_ok ? mem[fetch_idx] : 32'd0;
               step_q <= ST_DECODE;
            end
            ST_DECODE: begin
               if (dec_stop) begin
                  halted_q <= 1'b1;
                  step_q   <= ST_HALT;
               end else begin
                  ctrl_q <= dec_ctrl;
                  imm_q  <= dec_imm;
                  boff_q <= dec_boff;
                  rs1_q  <= dec_rs1;
                  rs2_q  <= dec_rs2;
                  rd_q   <= dec_rd;
                  step_q <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               aout_q  <= alu_y;
               sdata_q <= r2;
               pc_q    <= (ctrl_q.branch && alu_flag) ? pc_q + boff_q : pc_q + 32'd4;
               step_q  <= ST_MEM;
            end
            ST_MEM: begin
               if (ctrl_q.mread)
                  mout_q <= data_ok ? mem[data_idx] : '0;
               step_q <= ST_WB;
            end
            ST_WB: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_LAST) begin
                  halted_q <= 1'b1;
                  step_q   <= ST_HALT;
               end else begin
                  step_q <= ST_FETCH;
               end
            end
            default: step_q <= ST_HALT;
         endcase
      end
   end

   assign pc     = pc_q;
   assign halted = halted_q;

endmodule

// File: rtl/seqrv_chk.sv
module seqrv_chk
   import seqrv_pkg::*;
#(
   parameter int MAX_INSTR = 10000,
   parameter int CW        = 14
) (
   input logic          clk,
   input logic          rst_n,
   input logic          halted,
   input logic [31:0]   pc,
   input logic [4:0]    peek_sel,
   input logic [31:0]   peek_data,
   input step_t         step,
   input logic          mread,
   input logic          mwrite,
   input logic [CW-1:0] cnt
);

   AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      pc[1:0] == 2'b00);                                              // R10

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(pc));                              // R6

   AST_PC_MOVES_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc) |-> $past(step) == ST_EXEC);                       // R2

   AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (peek_sel == 5'd0) |-> (peek_data == 32'd0));                   // R8

   AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAX_INSTR));                                         // R7

   AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_MEM) |-> !(mread && mwrite));                       // R4

   AST_HALT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> step == ST_HALT);                                    // R6

endmodule

bind seqrv_core seqrv_chk #(.MAX_INSTR(MAX_INSTR), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .halted    (halted),
   .pc        (pc),
   .peek_sel  (peek_sel),
   .peek_data (peek_data),
   .step      (step_q),
   .mread     (ctrl_q.mread),
   .mwrite    (ctrl_q.mwrite),
   .cnt       (cnt_q)
);

// File: tb/sim_seqrv_core.sv
`timescale 1ns/1ps
module sim_seqrv_core;

   localparam int WORDS  = 1000;
   localparam int BUDGET = 10000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_we = 1'b0;
   logic [9:0]  load_addr = '0;
   logic [31:0] load_data = '0;
   logic [4:0]  peek_sel = '0;
   logic [31:0] peek_data;
   logic [31:0] pc;
   logic        halted;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   seqrv_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (load_we),
      .load_addr (load_addr),
      .load_data (load_data),
      .peek_sel  (peek_sel),
      .peek_data (peek_data),
      .pc        (pc),
      .halted    (halted)
   );

   // encoders
   function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2, input int rs1, input int rd);
      return {f7, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_addi(input int rd, input int rs1, input int imm);
      logic [11:0] i = 12'(imm);
      return {i, 5'(rs1), 3'b000, 5'(rd), 7'b0010011};
   endfunction
   function automatic logic [31:0] enc_lw(input int rd, input int rs1, input int imm);
      logic [11:0] i = 12'(imm);
      return {i, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
   endfunction
   function automatic logic [31:0] enc_sw(input int rs2, input int rs1, input int imm);
      logic [11:0] i = 12'(imm);
      return {i[11:5], 5'(rs2), 5'(rs1), 3'b010, i[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_br(input logic [2:0] f3, input int rs1, input int rs2, input int off);
      logic [12:0] o = 13'(off);
      return {o[12], o[10:5], 5'(rs2), 5'(rs1), f3, o[4:1], o[11], 7'b1100011};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic put(input int idx, input logic [31:0] w);
      @(negedge clk);
      load_we = 1'b1; load_addr = 10'(idx); load_data = w;
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic wipe();
      rst_n = 1'b0;
      for (int i = 0; i < WORDS; i++) begin
         @(negedge clk);
         load_we = 1'b1; load_addr = 10'(i); load_data = '0;
      end
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic run(input int limit, output int edges);
      @(negedge clk);
      rst_n = 1'b1;
      edges = 0;
      while (!halted && edges < limit) begin
         @(negedge clk);
         edges++;
      end
   endtask

   task automatic reg_is(input string req, input int r, input logic [31:0] exp);
      peek_sel = 5'(r);
      #1;
      chk(req, $sformatf("x%0d", r), peek_data, exp);
   endtask

   task automatic t_sum();
      int e;
      wipe();
      put(0, enc_addi(4, 0, 0));
      put(1, enc_addi(5, 0, 1));
      put(2, enc_addi(6, 0, 5));
      put(3, enc_br(3'b100, 6, 5, 16));
      put(4, enc_r(7'b0000000, 5, 4, 4));
      put(5, enc_addi(5, 5, 1));
      put(6, enc_br(3'b000, 0, 0, -12));
      run(1000, e);
      chk("R2", "cycles to halt for 24 instructions", 32'(e), 32'(5*24+2));
      chk("R6", "halted", {31'd0, halted}, 32'd1);
      chk("R6", "pc at stop word", pc, 32'd28);
      reg_is("R3", 4, 32'd15);
      reg_is("R3", 5, 32'd6);
      reg_is("R5", 6, 32'd5);
      repeat (5) @(negedge clk);
      chk("R6", "pc held after halt", pc, 32'd28);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "pc in reset", pc, 32'd0);
      chk("R1", "halted in reset", {31'd0, halted}, 32'd0);
      reg_is("R1", 4, 32'd0);
      reg_is("R1", 5, 32'd0);
   endtask

   task automatic t_mem();
      int e;
      wipe();
      put(30, 32'h1234_5678);
      put(0, enc_addi(1, 0, 100));
      put(1, enc_addi(2, 0, -7));
      put(2, enc_r(7'b0100000, 2, 1, 3));
      put(3, enc_sw(3, 1, -4));
      put(4, enc_lw(7, 0, 96));
      put(5, enc_r(7'b0000000, 2, 7, 8));
      put(6, enc_addi(0, 0, 5));
      put(7, enc_lw(9, 0, 120));
      put(8, enc_lw(10, 0, 4000));
      run(1000, e);
      chk("R2", "cycles to halt for 9 instructions", 32'(e), 32'(5*9+2));
      reg_is("R3", 2, 32'hFFFF_FFF9);
      reg_is("R3", 3, 32'd107);
      reg_is("R4", 7, 32'd107);
      reg_is("R3", 8, 32'd100);
      reg_is("R8", 0, 32'd0);
      reg_is("R9", 9, 32'h1234_5678);
      reg_is("R4", 10, 32'd0);
   endtask

   task automatic t_branch();
      int e;
      wipe();
      put(0,  enc_addi(1, 0, -1));
      put(1,  enc_addi(2, 0, 1));
      put(2,  enc_br(3'b100, 1, 2, 8));
      put(3,  enc_addi(10, 0, 99));
      put(4,  enc_br(3'b101, 1, 2, 8));
      put(5,  enc_addi(11, 0, 7));
      put(6,  enc_br(3'b001, 1, 1, 8));
      put(7,  enc_addi(12, 0, 3));
      put(8,  enc_br(3'b000, 0, 0, 8));
      put(9,  enc_addi(13, 0, 1));
      put(10, enc_br(3'b101, 2, 2, 8));
      put(11, enc_addi(14, 0, 1));
      run(1000, e);
      chk("R5", "pc at stop word", pc, 32'd48);
      reg_is("R5", 10, 32'd0);
      reg_is("R5", 11, 32'd7);
      reg_is("R5", 12, 32'd3);
      reg_is("R5", 13, 32'd0);
      reg_is("R5", 14, 32'd0);
   endtask

   task automatic t_budget();
      int e;
      wipe();
      put(0, enc_br(3'b000, 0, 0, 0));
      run(5*BUDGET - 1, e);
      chk("R7", "not halted one edge early", {31'd0, halted}, 32'd0);
      @(negedge clk);
      chk("R7", "halted at budget", {31'd0, halted}, 32'd1);
      chk("R7", "pc on self loop", pc, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_sum();
      t_reset();
      t_mem();
      t_branch();
      t_budget();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule